// File: doc/BRIEF.md
# Piecewise-Affine Softmax Engine

This block turns a row of signed fixed-point scores into a row of unsigned probabilities without any exponential hardware and with a single division-like operation per row. A row passes through four phases. First the largest score is found. Then each score is shifted down by that maximum and run through a four-segment affine approximation of exp(), and the results are summed. Next one reciprocal of the sum is formed by an iterative shift-subtract unit. Finally every approximated exponential is scaled by the reciprocal and emitted.

Scores enter on a valid/ready stream with an end-of-row marker. Probabilities leave on a valid-only stream, one per cycle at most, with the final element of the row flagged. In buffered mode the engine captures the row once into internal storage and reads it back for the later phases. In streaming mode nothing is stored: upstream presents the same row again whenever the engine asks for it, for the accumulate phase and for the emit phase.

Top module: `pwa_softmax`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low and `in_ready` is high, so the first score of a row can be accepted at once.
- R2: The reference point is the largest score of the row (scores are signed Q4.8, 12 bits). The element equal to the maximum gets an exponential of exactly 65536 (1.0 in Q0.16).
- R3: With d = score - max in Q4.8 units (d is never positive), the exponential is 65536 + 128·d for d > -256, 40960 + 64·d for -512 < d <= -256, 16384 + 16·d for -1024 < d <= -512, 2048 + d for -2048 < d <= -1024, and 0 for d <= -2048 (x - max of -8.0 or lower).
- R4: With S the sum of the row's exponentials, the reciprocal is r = floor(2^32 / S); each output is floor(e·r / 65536), clamped to 65535, as unsigned Q0.16.
- R5: A row of N scores yields exactly N outputs in input order; `out_last` is high on the N-th output only.
- R6: In buffered mode (`stream_mode` = 0) the row is presented once; `in_ready` is low from the cycle after the last score is accepted until the cycle after the row's final output, and high again then.
- R7: A row ends after MAX_LEN (256) accepted scores even when no end marker arrives; the 256th score is treated as the last.
- R8: In streaming mode (`stream_mode` = 1) upstream presents the row three times (max phase, accumulate phase, emit phase). The two replays end by the length counted in the first pass, so `in_last` is ignored during them, and `in_ready` is low while the reciprocal is computed.
- R9: In streaming mode, a cycle with `in_valid` low stalls the current phase without losing data, and each score accepted in the emit phase produces its output in the next cycle.
- R10: The mode is taken from `stream_mode` when a row's first score is accepted; later changes within that row have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stream_mode | input | 1 | 1 selects streaming (replayed rows), 0 selects buffered |
| in_valid | input | 1 | Score on `in_score` is valid |
| in_ready | output | 1 | Engine accepts a score this cycle |
| in_score | input | SCORE_W (12) | Signed Q4.8 score |
| in_last | input | 1 | Marks the final score of a row in the first pass |
| out_valid | output | 1 | Probability on `out_prob` is valid |
| out_prob | output | PROB_W (16) | Unsigned Q0.16 probability |
| out_last | output | 1 | Marks the final probability of a row |

## Verification
The assertions watch, every cycle, that the reciprocal unit's quotient is the exact floor of 2^32 over the sum it was given and that the sum is never below 1.0, that the exponential unit returns 1.0 at zero distance, stays at or below 1.0 and drops to zero past -8.0, and that the input stays closed while the reciprocal runs or a buffered row is still being emitted. They also tie every streaming output to an accepted score in the cycle before and every end flag to a valid output. Only the bench's rows can show the actual probability values per segment, the clamping of a lone element, the 256-element cap, the ignored replay end markers, stalls with gaps and the latching of the mode at row start.

// File: rtl/pwa_softmax_pkg.sv
`timescale 1ns/1ps
package pwa_softmax_pkg;

  typedef enum logic [1:0] {
    ST_MAX  = 2'd0,
    ST_ACC  = 2'd1,
    ST_RCP  = 2'd2,
    ST_EMIT = 2'd3
  } sm_state_e;

  localparam int NUM_SEG = 4;

  // Left shift applied to d for segment idx: slopes 1/2, 1/4, 1/16, 1/256.
  function automatic int seg_shift(input int idx, input int prob_w, input int frac_w);
    int drop;
    case (idx)
      0:       drop = 1;
      1:       drop = 2;
      2:       drop = 4;
      default: drop = 8;
    endcase
    return prob_w - frac_w - drop;
  endfunction

  // Intercept of segment idx in the output scale: 1, 5/8, 1/4, 1/32.
  function automatic int seg_icpt(input int idx, input int prob_w);
    case (idx)
      0:       return 1 << prob_w;
      1:       return 5 << (prob_w - 3);
      2:       return 1 << (prob_w - 2);
      default: return 1 << (prob_w - 5);
    endcase
  endfunction

endpackage

// File: rtl/pwa_exp_unit.sv
`timescale 1ns/1ps
module pwa_exp_unit
  import pwa_softmax_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int PROB_W = 16,
  parameter int DIFF_W = 13,
  parameter int EXP_W  = PROB_W + 1
) (
  input  logic signed [DIFF_W-1:0] d,
  output logic        [EXP_W-1:0]  e
);

  localparam int UNIT = 1 << FRAC_W;

  int   dv;
  logic [NUM_SEG-1:0] seg_hit;
  int   seg_val [NUM_SEG];
  int   pick;

  assign dv = int'(d);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam int LOWER = -(UNIT << g);
    localparam int SH    = seg_shift(g, PROB_W, FRAC_W);
    localparam int ICPT  = seg_icpt(g, PROB_W);
    assign seg_hit[g] = (dv > LOWER);
    assign seg_val[g] = ICPT + (dv <<< SH);
  end

  always_comb begin
    pick = 0;
    for (int k = NUM_SEG - 1; k >= 0; k--) begin
      if (seg_hit[k]) pick = seg_val[k];
    end
  end

  assign e = EXP_W'(pick);

endmodule

// File: rtl/pwa_recip_unit.sv
`timescale 1ns/1ps
module pwa_recip_unit #(
  parameter int SUM_W  = 25,
  parameter int Q_W    = 17,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SUM_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quotient
);

  localparam int REM_W = 2 * FRAC_W + 1;
  localparam int DV_W  = SUM_W + Q_W;
  localparam int CNT_W = $clog2(Q_W + 1);

  logic [REM_W-1:0] rem_q, rem_n;
  logic [DV_W-1:0]  dv_q, dv_n, rem_ext;
  logic [Q_W-1:0]   quo_q, quo_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n, done_q, done_n;

  assign rem_ext = DV_W'(rem_q);

  always_comb begin
    rem_n  = rem_q;
    dv_n   = dv_q;
    quo_n  = quo_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (start) begin
      rem_n  = REM_W'(1) << (2 * FRAC_W);
      dv_n   = DV_W'(divisor) << (Q_W - 1);
      quo_n  = '0;
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (busy_q) begin
      if (rem_ext >= dv_q) begin
        rem_n = REM_W'(rem_ext - dv_q);
        quo_n = {quo_q[Q_W-2:0], 1'b1};
      end else begin
        quo_n = {quo_q[Q_W-2:0], 1'b0};
      end
      dv_n  = dv_q >> 1;
      cnt_n = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(Q_W - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dv_q   <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      dv_q   <= dv_n;
      quo_q  <= quo_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = quo_q;

endmodule

// File: rtl/pwa_row_buffer.sv
`timescale 1ns/1ps
module pwa_row_buffer #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WIDTH-1:0]         rd_data
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/pwa_softmax.sv
`timescale 1ns/1ps
module pwa_softmax
  import pwa_softmax_pkg::*;
#(
  parameter int SCORE_W = 12,
  parameter int FRAC_W  = 8,
  parameter int PROB_W  = 16,
  parameter int MAX_LEN = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stream_mode,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [SCORE_W-1:0] in_score,
  input  logic               in_last,
  output logic               out_valid,
  output logic [PROB_W-1:0]  out_prob,
  output logic               out_last
);

  localparam int IDX_W  = $clog2(MAX_LEN);
  localparam int LEN_W  = IDX_W + 1;
  localparam int DIFF_W = SCORE_W + 1;
  localparam int EXP_W  = PROB_W + 1;
  localparam int SUM_W  = EXP_W + IDX_W;
  localparam int PROD_W = 2 * EXP_W;
  localparam logic [PROD_W-1:0] PMAX = PROD_W'((1 << PROB_W) - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sm_state_e                  state_q, state_n;
  logic                       mode_q, mode_n;
  logic signed [SCORE_W-1:0]  max_q, max_n;
  logic [LEN_W-1:0]           cnt_q, cnt_n;
  logic [LEN_W-1:0]           len_q, len_n;
  logic [SUM_W-1:0]           sum_q, sum_n;
  logic                       launched_q, launched_n;
  logic                       ov_q, ov_n;
  logic [PROB_W-1:0]          op_q, op_n;
  logic                       ol_q, ol_n;

  logic                       in_fire, step, at_end, row_mode;
  logic                       wr_en, rcp_start, rcp_busy, rcp_done, emit_fire;
  logic [SCORE_W-1:0]         rd_data, cur_score;
  logic signed [DIFF_W-1:0]   exp_d;
  logic [EXP_W-1:0]           exp_e;
  logic [EXP_W-1:0]           rcp_quot;
  logic [PROD_W-1:0]          prod, shifted;
  logic [PROB_W-1:0]          scaled;

  assign in_ready  = (state_q == ST_MAX) ||
                     (mode_q && ((state_q == ST_ACC) || (state_q == ST_EMIT)));
  assign in_fire   = in_valid && in_ready;
  assign step      = mode_q ? in_fire : 1'b1;
  assign at_end    = ((cnt_q + LEN_W'(1)) == len_q);
  assign row_mode  = (cnt_q == '0) ? stream_mode : mode_q;
  assign cur_score = mode_q ? in_score : rd_data;
  assign exp_d     = $signed({cur_score[SCORE_W-1], cur_score}) -
                     $signed({max_q[SCORE_W-1], max_q});

  pwa_row_buffer #(.WIDTH(SCORE_W), .DEPTH(MAX_LEN)) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (cnt_q[IDX_W-1:0]),
    .wr_data (in_score),
    .rd_addr (cnt_q[IDX_W-1:0]),
    .rd_data (rd_data)
  );

  pwa_exp_unit #(.FRAC_W(FRAC_W), .PROB_W(PROB_W), .DIFF_W(DIFF_W), .EXP_W(EXP_W)) u_exp (
    .d (exp_d),
    .e (exp_e)
  );

  pwa_recip_unit #(.SUM_W(SUM_W), .Q_W(EXP_W), .FRAC_W(PROB_W)) u_rcp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (rcp_start),
    .divisor  (sum_q),
    .busy     (rcp_busy),
    .done     (rcp_done),
    .quotient (rcp_quot)
  );

  // scale: e * r, drop the fraction, clamp to the largest Q0.16 value
  assign prod    = PROD_W'(exp_e) * PROD_W'(rcp_quot);
  assign shifted = prod >> PROB_W;
  assign scaled  = (shifted > PMAX) ? {PROB_W{1'b1}} : PROB_W'(shifted);

  always_comb begin
    state_n    = state_q;
    mode_n     = mode_q;
    max_n      = max_q;
    cnt_n      = cnt_q;
    len_n      = len_q;
    sum_n      = sum_q;
    launched_n = launched_q;
    ov_n       = 1'b0;
    op_n       = op_q;
    ol_n       = 1'b0;
    wr_en      = 1'b0;
    rcp_start  = 1'b0;
    emit_fire  = 1'b0;
    case (state_q)
      ST_MAX: begin
        if (in_fire) begin
          mode_n = row_mode;
          wr_en  = !row_mode;
          if ((cnt_q == '0) || ($signed(in_score) > max_q)) max_n = $signed(in_score);
          if (in_last || (cnt_q == LEN_W'(MAX_LEN - 1))) begin
            len_n   = cnt_q + LEN_W'(1);
            cnt_n   = '0;
            sum_n   = '0;
            state_n = ST_ACC;
          end else begin
            cnt_n = cnt_q + LEN_W'(1);
          end
        end
      end
      ST_ACC: begin
        if (step) begin
          sum_n = sum_q + SUM_W'(exp_e);
          if (at_end) begin
            cnt_n      = '0;
            launched_n = 1'b0;
            state_n    = ST_RCP;
          end else begin
            cnt_n = cnt_q + LEN_W'(1);
          end
        end
      end
      ST_RCP: begin
        rcp_start  = !launched_q;
        launched_n = 1'b1;
        if (rcp_done) state_n = ST_EMIT;
      end
      ST_EMIT: begin
        if (step) begin
          emit_fire = 1'b1;
          ov_n      = 1'b1;
          op_n      = scaled;
          ol_n      = at_end;
          if (at_end) begin
            cnt_n   = '0;
            state_n = ST_MAX;
          end else begin
            cnt_n = cnt_q + LEN_W'(1);
          end
        end
      end
      default: state_n = ST_MAX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_MAX;
      mode_q     <= 1'b0;
      max_q      <= '0;
      cnt_q      <= '0;
      len_q      <= '0;
      sum_q      <= '0;
      launched_q <= 1'b0;
      ov_q       <= 1'b0;
      op_q       <= '0;
      ol_q       <= 1'b0;
    end else begin
      state_q    <= state_n;
      mode_q     <= mode_n;
      max_q      <= max_n;
      cnt_q      <= cnt_n;
      len_q      <= len_n;
      sum_q      <= sum_n;
      launched_q <= launched_n;
      ov_q       <= ov_n;
      op_q       <= op_n;
      ol_q       <= ol_n;
    end
  end

  assign out_valid = ov_q;
  assign out_prob  = op_q;
  assign out_last  = ol_q;

endmodule

// File: rtl/pwa_softmax_chk.sv
`timescale 1ns/1ps
module pwa_softmax_chk #(
  parameter int SCORE_W = 12,
  parameter int FRAC_W  = 8,
  parameter int PROB_W  = 16,
  parameter int MAX_LEN = 256
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             mode_q,
  input logic                             in_valid,
  input logic                             in_ready,
  input logic                             out_valid,
  input logic                             out_last,
  input logic                             rcp_busy,
  input logic                             rcp_done,
  input logic [PROB_W:0]                  rcp_quot,
  input logic [PROB_W+$clog2(MAX_LEN):0]  sum_q,
  input logic signed [SCORE_W:0]          exp_d,
  input logic [PROB_W:0]                  exp_e
);

  localparam int          SUM_W = PROB_W + 1 + $clog2(MAX_LEN);
  localparam int          ONE   = 1 << PROB_W;
  localparam int          FLOOR = -(8 << FRAC_W);
  localparam logic [63:0] NUM   = 64'd1 << (2 * PROB_W);

  // R4: the quotient is the exact floor of 2^32 / sum
  p_quot_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rcp_done |-> ((64'(rcp_quot) * 64'(sum_q) <= NUM) &&
                  ((64'(rcp_quot) + 64'd1) * 64'(sum_q) > NUM)));

  // R2: the maximum always contributes 1.0, so the sum never falls below it
  p_sum_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rcp_done |-> (sum_q >= SUM_W'(ONE)));

  // R2: zero distance from the maximum gives exactly 1.0
  p_exp_peak_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_d == '0) |-> (exp_e == (PROB_W + 1)'(ONE)));

  // R3: non-positive distances never exceed 1.0
  p_exp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(exp_d) <= 0) |-> (exp_e <= (PROB_W + 1)'(ONE)));

  // R3: at or below -8.0 the exponential is zero
  p_exp_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(exp_d) <= FLOOR) |-> (exp_e == '0));

  // R5: an end flag only comes with a valid output
  p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R8: input closed while the reciprocal runs
  p_rcp_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rcp_busy |-> !in_ready);

  // R6: input closed while a buffered row is still being emitted
  p_buf_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && out_valid && !out_last) |-> !in_ready);

  // R9: a streaming output follows an accepted score one cycle earlier
  p_out_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && out_valid) |-> $past(in_valid && in_ready));

endmodule

bind pwa_softmax pwa_softmax_chk #(
  .SCORE_W (SCORE_W),
  .FRAC_W  (FRAC_W),
  .PROB_W  (PROB_W),
  .MAX_LEN (MAX_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mode_q    (mode_q),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_last  (out_last),
  .rcp_busy  (rcp_busy),
  .rcp_done  (rcp_done),
  .rcp_quot  (rcp_quot),
  .sum_q     (sum_q),
  .exp_d     (exp_d),
  .exp_e     (exp_e)
);

// File: tb/tb_pwa_softmax.sv
`timescale 1ns/1ps
module tb_pwa_softmax;

  logic        clk;
  logic        rst_n;
  logic        stream_mode;
  logic        in_valid;
  logic        in_ready;
  logic [11:0] in_score;
  logic        in_last;
  logic        out_valid;
  logic [15:0] out_prob;
  logic        out_last;

  int checks;
  int errors;
  bit finished;

  typedef struct { int p; bit l; } exp_t;
  exp_t exp_q[$];

  pwa_softmax dut (
    .clk(clk), .rst_n(rst_n), .stream_mode(stream_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_score(in_score), .in_last(in_last),
    .out_valid(out_valid), .out_prob(out_prob), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  // R3 segment law, written from the requirement
  function automatic int exp_ref(input int d);
    if (d > -256)       return 65536 + d * 128;
    else if (d > -512)  return 40960 + d * 64;
    else if (d > -1024) return 16384 + d * 16;
    else if (d > -2048) return 2048 + d;
    else                return 0;
  endfunction

  task automatic predict(input int s[$]);
    int mx;
    longint sum;
    longint r;
    longint p;
    exp_t item;
    mx = s[0];
    foreach (s[i]) if (s[i] > mx) mx = s[i];
    sum = 0;
    foreach (s[i]) sum += exp_ref(s[i] - mx);
    r = (64'sd1 <<< 32) / sum;
    foreach (s[i]) begin
      p = (longint'(exp_ref(s[i] - mx)) * r) >>> 16;
      if (p > 65535) p = 65535;
      item.p = int'(p);
      item.l = (i == s.size() - 1);
      exp_q.push_back(item);
    end
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 output with none expected", out_prob, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_prob == 16'(e.p), "R3/R4 probability", out_prob, e.p);
        chk(out_last == e.l, "R5 end flag", out_last, e.l);
      end
    end
  end

  task automatic send(input int score, input bit last, input int gap);
    bit got;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_score = 12'(score);
    in_last  = last;
    got = 1'b0;
    while (!got) begin
      #1;
      got = in_ready;
      @(posedge clk);
      if (!got) @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic buffered_row(input int s[$]);
    stream_mode = 1'b0;
    predict(s);
    foreach (s[i]) send(s[i], i == s.size() - 1, 0);
    idle();
    chk(in_ready == 1'b0, "R6 closed after last", in_ready, 0);
    drain();
    chk(in_ready == 1'b1, "R6 open after row", in_ready, 1);
  endtask

  task automatic stream_row(input int s[$], input int gap, input bit early_last);
    stream_mode = 1'b1;
    predict(s);
    foreach (s[i]) send(s[i], i == s.size() - 1, 0);
    foreach (s[i]) send(s[i], (i == s.size() - 1) || (early_last && i == 0), gap);
    foreach (s[i]) begin
      send(s[i], i == s.size() - 1, gap);
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1, "R9 output one cycle after accept", out_valid, 1);
    end
    idle();
    drain();
  endtask

  initial begin
    int row[$];
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; stream_mode = 1'b0;
    in_valid = 1'b0; in_score = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(out_last == 1'b0, "R1 out_last after reset", out_last, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R2/R3 every segment, maximum in the middle, floor at exactly -8.0
    row = {384, 256, 512, 128, -256, -1024, -1536, -2048};
    buffered_row(row);

    // R4 lone element saturates to 65535, R5 flag on it
    row = {-700};
    buffered_row(row);

    // R4 equal scores split evenly
    row = {100, 100, 100, 100, 100, 100, 100, 100};
    buffered_row(row);

    // R8/R9 streaming with gaps and an early end marker in the replay
    row = {384, 256, 512, 128, -256, -1024, -1536, -2048};
    stream_row(row, 2, 1'b1);

    // R8 streaming, all negative, back to back
    row = {-300, -900, -1200};
    stream_row(row, 0, 1'b0);

    // R10 mode change after the first score is ignored
    row = {10, -50, 300, -400, 0};
    stream_mode = 1'b0;
    predict(row);
    foreach (row[i]) begin
      send(row[i], i == row.size() - 1, 0);
      if (i == 0) begin
        #1 stream_mode = 1'b1;
      end
    end
    idle();
    chk(in_ready == 1'b0, "R10 buffered row stays buffered", in_ready, 0);
    drain();
    stream_mode = 1'b0;

    // R7 256 scores and no end marker
    row = {};
    for (int i = 0; i < 256; i++) row.push_back(((i * 37) % 2000) - 1000);
    predict(row);
    foreach (row[i]) send(row[i], 1'b0, 0);
    idle();
    chk(in_ready == 1'b0, "R7 row closed at 256", in_ready, 0);
    drain();
    chk(exp_q.size() == 0, "R7 all 256 outputs seen", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R5 no stray outputs", out_valid, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual %0d expected %0d", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule